// File: doc/BRIEF.md
# Node Address Range Decoder

This block sorts each request address that reaches a node into one target class. It takes a 40-bit physical address, the source of the request, a request-kind code and two programmed MMIO base values. One clock later it returns a target code, an attribute that marks MMIO traffic, and a flag that reports an illegal cacheable access to MMIO space.

The address map has three parts. The first is a fixed chipset window below 4 GB. Inside that window sits a small local register hole, which only the processor bus may reach. The second is a low MMIO window whose top is fixed just under that chipset window. Its base is programmable in 64 MB steps. The third is a high MMIO window that reaches the top of the 40-bit space. Its base is programmable in 4 GB steps. Any address outside all of these goes to the memory/other class. Interleave decoding, register storage and port transport are left to other blocks.

Top module: `node_addr_decode`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `req_valid` high, and falls one clock after a cycle with `req_valid` low. While `out_valid` is low, `out_target`, `out_attr` and `out_cache_err` are all zero.
- R2: A processor-bus request (`req_src`=0) for an address in 0xFE60_0000..0xFE6F_FFFF gets `out_target`=1 (local registers), with `out_attr`=0.
- R3: Any address in 0xFE00_0000..0xFFBF_FFFF other than the processor-bus register hole gets `out_target`=3 (master abort). This includes register-hole addresses that come from a scalability port (`req_src`=1).
- R4: The low MMIO window covers addresses from the low base up to 0xFDFF_FFFF, with bits [39:32] zero. The low base is `low_base` shifted left by 26 (64 MB steps). A processor-bus hit gets `out_target`=2 (default port) and `out_attr`=1 (MMIO).
- R5: A `low_base` of 0 is clamped to the floor 0x0400_0000. Addresses below the effective low base are not MMIO.
- R6: The high MMIO window covers addresses from `high_base` shifted left by 32 up to 0xFF_FFFF_FFFF. A `high_base` of 0 is clamped to 0x1_0000_0000. A processor-bus hit gets `out_target`=2 and `out_attr`=1.
- R7: `req_kind` codes: 0 uncached read, 1 uncached write, 2 write-back, 3 write-through, 4 cache flush, 5..7 uncached. Kind 2 or 3 to an MMIO window sets `out_cache_err`=1, and the target stays 2. A flush or uncached kind gives `out_cache_err`=0. `out_cache_err` is never set for a non-MMIO target.
- R8: An MMIO-window address from a scalability port gets `out_target`=3, with `out_attr`=0 and `out_cache_err`=0.
- R9: Every other address gets `out_target`=0 (memory/other), `out_attr`=0 and `out_cache_err`=0. This includes 0xFFC0_0000..0xFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 40 | Physical address |
| req_src | input | 1 | 0 processor bus, 1 scalability port |
| req_kind | input | 3 | Request kind code (see R7) |
| low_base | input | 6 | Low MMIO base, address bits [31:26] |
| high_base | input | 8 | High MMIO base, address bits [39:32] |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_target | output | 2 | 0 other, 1 local registers, 2 MMIO default port, 3 master abort |
| out_attr | output | 2 | 0 none, 1 MMIO |
| out_cache_err | output | 1 | Illegal cacheable access to MMIO |

## Verification
The bench probes both edges of every window. Those are the register hole bounds, the chipset window bounds, and each MMIO base with the address one below it. An off-by-one compare would put these edge addresses in the wrong class. The bench programs base values of zero to test the clamps. A design without the clamp would then send the region below 64 MB or below 4 GB to MMIO. The bench also sends register-hole and MMIO addresses from a scalability port, where a design that ignores the source would return local or MMIO targets instead of an abort. It sends write-back, write-through and flush requests to MMIO and to memory, so that an error flag raised for flushes, or raised outside MMIO, is caught.

// File: rtl/node_addr_decode.sv
module node_addr_decode #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_src,
  input  logic [2:0]    req_kind,
  input  logic [5:0]    low_base,
  input  logic [7:0]    high_base,
  output logic          out_valid,
  output logic [1:0]    out_target,
  output logic [1:0]    out_attr,
  output logic          out_cache_err
);
  localparam logic [1:0] T_OTHER = 2'd0, T_LOCAL = 2'd1, T_MMIO = 2'd2, T_ABORT = 2'd3;
  localparam logic [1:0] A_NONE = 2'd0, A_MMIO = 2'd1;

  logic        below4g;
  logic [31:0] a32;
  logic [5:0]  low_eff;
  logic [AW-33:0] high_eff;
  logic        in_chip, in_regs, in_low, in_high, in_mmio, cacheable;
  logic [1:0]  tgt_d, attr_d;
  logic        err_d;

  assign below4g   = (req_addr[AW-1:32] == '0);
  assign a32       = req_addr[31:0];
  assign low_eff   = (low_base == 6'd0) ? 6'd1 : low_base;
  assign high_eff  = (high_base == '0) ? {{(AW-33){1'b0}}, 1'b1} : high_base;
  assign in_chip   = below4g && a32 >= 32'hFE00_0000 && a32 <= 32'hFFBF_FFFF;
  assign in_regs   = below4g && a32[31:20] == 12'hFE6;
  assign in_low    = below4g && a32[31:26] >= low_eff && a32 <= 32'hFDFF_FFFF;
  assign in_high   = req_addr[AW-1:32] >= high_eff;
  assign in_mmio   = in_low || in_high;
  assign cacheable = (req_kind == 3'd2) || (req_kind == 3'd3);

  always_comb begin
    tgt_d  = T_OTHER;
    attr_d = A_NONE;
    err_d  = 1'b0;
    if (in_chip) begin
      tgt_d = (in_regs && !req_src) ? T_LOCAL : T_ABORT;
    end else if (in_mmio) begin
      if (req_src) begin
        tgt_d = T_ABORT;
      end else begin
        tgt_d  = T_MMIO;
        attr_d = A_MMIO;
        err_d  = cacheable;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_target    <= T_OTHER;
      out_attr      <= A_NONE;
      out_cache_err <= 1'b0;
    end else begin
      out_valid     <= req_valid;
      out_target    <= req_valid ? tgt_d  : T_OTHER;
      out_attr      <= req_valid ? attr_d : A_NONE;
      out_cache_err <= req_valid && err_d;
    end
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_target == T_OTHER && out_attr == A_NONE && !out_cache_err));
  assert_port_no_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src) |=> out_target != T_LOCAL);
  assert_attr_tracks_mmio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_attr == A_MMIO) == (out_target == T_MMIO)));
  assert_err_only_mmio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_cache_err |-> out_target == T_MMIO);
  assert_flush_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd4) |=> !out_cache_err);
endmodule

// File: tb/node_addr_decode_test.sv
module node_addr_decode_test;
  logic        clk = 0, rst_n = 0, req_valid = 0, req_src = 0;
  logic [39:0] req_addr = '0;
  logic [2:0]  req_kind = '0;
  logic [5:0]  low_base = 6'd2;
  logic [7:0]  high_base = 8'd3;
  logic        out_valid, out_cache_err;
  logic [1:0]  out_target, out_attr;
  int checks = 0, errors = 0;
  logic [4:0]  expq[$];
  string       tagq[$];
  bit          done = 0;

  always #2 clk = ~clk;

  node_addr_decode uut (.*);

  function automatic logic [4:0] model(logic [39:0] a, logic s, logic [2:0] k);
    logic [39:0] lb, hb;
    lb = 40'(low_base == 0 ? 1 : low_base) * 40'h400_0000;
    hb = 40'(high_base == 0 ? 1 : high_base) * 40'h1_0000_0000;
    if (a >= 40'hFE00_0000 && a <= 40'hFFBF_FFFF) begin
      if (a >= 40'hFE60_0000 && a <= 40'hFE6F_FFFF && !s) return {2'd1, 2'd0, 1'b0};
      return {2'd3, 2'd0, 1'b0};
    end
    if ((a >= lb && a <= 40'hFDFF_FFFF) || a >= hb) begin
      if (s) return {2'd3, 2'd0, 1'b0};
      return {2'd2, 2'd1, (k == 3'd2 || k == 3'd3)};
    end
    return 5'd0;
  endfunction

  task automatic drive(logic [39:0] a, logic s, logic [2:0] k, string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_src = s; req_kind = k;
    expq.push_back(model(a, s, k));
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [4:0] e;
    string t;
    if (out_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++; $display("FAIL R1 unexpected out_valid actual 1 expected 0");
      end else begin
        e = expq.pop_front(); t = tagq.pop_front();
        if ({out_target, out_attr, out_cache_err} !== e) begin
          errors++;
          $display("FAIL %s actual tgt=%0d attr=%0d err=%0d expected tgt=%0d attr=%0d err=%0d",
                   t, out_target, out_attr, out_cache_err, e[4:3], e[2:1], e[0]);
        end
      end
    end else if (!done && expq.size() == 0) begin
      checks++;
      if ({out_target, out_attr, out_cache_err} !== 5'd0) begin
        errors++; $display("FAIL R1 idle fields actual %b expected 0", {out_target, out_attr, out_cache_err});
      end
    end
  end

  initial begin
    #200000;
    errors++; $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0) begin errors++; $display("FAIL R1 reset out_valid actual %b expected 0", out_valid); end
    rst_n = 1;
    drive(40'hFE60_0000, 0, 0, "R2 hole low edge");
    drive(40'hFE6F_FFFF, 0, 1, "R2 hole high edge");
    drive(40'hFE5F_FFFF, 0, 0, "R3 below hole");
    drive(40'hFE70_0000, 0, 0, "R3 above hole");
    drive(40'hFE00_0000, 0, 0, "R3 chip low edge");
    drive(40'hFFBF_FFFF, 0, 0, "R3 chip high edge");
    drive(40'hFE65_0000, 1, 0, "R3 hole from port");
    drive(40'hFFC0_0000, 0, 0, "R9 above chip window");
    drive(40'h07FF_FFFF, 0, 0, "R4 below low base");
    drive(40'h0800_0000, 0, 0, "R4 low base edge");
    drive(40'hFDFF_FFFF, 0, 1, "R4 low top edge");
    drive(40'h0800_0000, 0, 2, "R7 write-back low mmio");
    drive(40'hFDFF_0000, 0, 3, "R7 write-through low mmio");
    drive(40'h0900_0000, 0, 4, "R7 flush low mmio");
    drive(40'h0100_0000, 0, 2, "R7 write-back memory");
    drive(40'h2_FFFF_FFFF, 0, 0, "R6 below high base");
    drive(40'h3_0000_0000, 0, 0, "R6 high base edge");
    drive(40'hFF_FFFF_FFFF, 0, 3, "R7 write-through high top");
    drive(40'h3_0000_0000, 1, 2, "R8 high from port");
    drive(40'h0800_0000, 1, 0, "R8 low from port");
    @(negedge clk); low_base = 0; high_base = 0;
    drive(40'h0400_0000, 0, 0, "R5 clamp floor");
    drive(40'h03FF_FFFF, 0, 0, "R5 below floor");
    drive(40'h1_0000_0000, 0, 0, "R6 clamp floor");
    drive(40'h0_FFFF_FFFF, 0, 0, "R9 below 4G top");
    @(negedge clk); low_base = 6'd63; high_base = 8'd255;
    drive(40'hFBFF_FFFF, 0, 0, "R5 below max low base");
    drive(40'hFC00_0000, 0, 0, "R4 max low base");
    drive(40'hFE_FFFF_FFFF, 0, 0, "R6 below max high base");
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      low_base = 6'($urandom); high_base = 8'($urandom % 8);
      drive({8'($urandom % 8), 32'($urandom)}, 1'($urandom), 3'($urandom), "R9 random");
    end
    repeat (3) @(negedge clk);
    done = 1;
    checks++;
    if (expq.size() != 0) begin errors++; $display("FAIL R1 missing results actual %0d expected 0", expq.size()); end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule